// File: doc/BRIEF.md
# Double-Buffered Configuration Port

This block is the register front end of a digital upconverter channel. A host reaches it over a word-wide memory-mapped bus: a 10-bit word address, a 16-bit data bus, a chip enable, and read and write strobes that are only honoured while the chip enable is high. The lower half of the address space holds a bank of 16-bit control words. The upper half belongs to the shaping-filter coefficient store, which lies outside this block. Writes there are handed on as a one-cycle coefficient write pulse with address and data.

The write strobe is asynchronous to the reference clock. It is synchronized into the clock domain, and its rising edge triggers exactly one register update. Two of the control words act as holding registers for a 30-bit resampler frequency. Word 2 holds the upper 14 bits and word 3 the lower 16. The active frequency at the output only changes as a whole. It is loaded either when word 3 is written, or on a clock edge where the external sync input is high while sync mode is enabled in word 22. A half-written value therefore never reaches the datapath.

Top module: `cfg_dbuf_port`

## Requirements
- R1: After reset every control word reads 0, the active frequency is 0, the coefficient pulse is low and the read bus is 0.
- R2: A write strobe raised while the chip enable is low changes no control word, no frequency bit and produces no coefficient pulse.
- R3: A rising edge of the enabled write strobe, first seen high at clock edge c, updates the addressed register at edge c+2 (so it is visible after edge c+2, three edges after the strobe went high between edges). Each rising edge causes exactly one update.
- R4: Writing word 3 loads the active frequency with bits 29:16 equal to bits 13:0 of word 2 and bits 15:0 equal to the new data, all in one clock edge.
- R5: Writing word 2 alone leaves the active frequency unchanged, and reading word 2 or word 3 returns the holding value last written.
- R6: When the sync input is high at a clock edge and bit 0 of word 22 is 1, the active frequency is loaded from words 2 and 3. When that bit is 0, the sync input has no effect.
- R7: A write to an address with bit 9 set produces a coefficient write pulse exactly one clock long, with the coefficient address equal to address bits 8:0 and the written data. No control word changes, and reading such an address returns 0.
- R8: The read bus is combinational. It shows the addressed control word while chip enable and read are both high, and is 0 otherwise.
- R9: Writes and reads at addresses from 32 up to 511 have no effect and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs | input | 1 | Chip enable, gates read and write |
| bus_wr | input | 1 | Write strobe, asynchronous, acts on its rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, 0 when not reading |
| sync_in | input | 1 | External sync pulse for the frequency transfer |
| rsmp_freq | output | 30 | Active resampler frequency word |
| ctrl_flat | output | 512 | All 32 control words, word n at bits 16n+15:16n |
| coef_we | output | 1 | One-cycle coefficient write pulse |
| coef_addr | output | 9 | Coefficient address of the last coefficient write |
| coef_data | output | 16 | Coefficient data of the last coefficient write |

## Verification
The bench builds the block with its default parameters: 32 control words, a two-stage strobe synchronizer and a 30-bit frequency. With these values the sync-mode word 22 is inside the bank and the unmapped gap from 32 to 511 lies above the bank, so both can be reached. The reference model predicts the three-edge write latency and the order of events when a sync and a holding-register write meet. Sync pulses are issued both with sync mode off and with it on, around writes to each holding half, to show that the active word never takes a mixed value.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/cfgp_strobe_sync.sv
module cfgp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fire
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], strobe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign fire = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile import cfgp_pkg::*; #(
  parameter int NUM_CW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-2:0]        waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ADDR_W-2:0]        raddr,
  output logic [DATA_W-1:0]        rdata,
  output logic [NUM_CW*DATA_W-1:0] words_flat
);
  localparam int AW = ADDR_W - 1;

  for (genvar i = 0; i < NUM_CW; i++) begin : g_word
    logic [DATA_W-1:0] word_q, word_d;
    logic              hit;

    assign hit = we && (waddr == AW'(i));

    always_comb begin
      word_d = word_q;
      if (hit) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= word_d;
    end

    assign words_flat[i*DATA_W +: DATA_W] = word_q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_CW; k++) begin
      if (raddr == AW'(k)) rdata = words_flat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/cfgp_freq_dbuf.sv
module cfgp_freq_dbuf #(
  parameter int FREQ_W = 30,
  parameter int LO_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [FREQ_W-LO_W-1:0] hold_hi,
  input  logic [LO_W-1:0]        hold_lo,
  input  logic [LO_W-1:0]        new_lo,
  input  logic                   load_lo,
  input  logic                   sync_take,
  output logic [FREQ_W-1:0]      freq_q
);
  logic [FREQ_W-1:0] freq_d;
  logic              freq_en;

  assign freq_en = load_lo | sync_take;

  always_comb begin
    freq_d = freq_q;
    if (sync_take) freq_d = {hold_hi, hold_lo};
    if (load_lo)   freq_d = {hold_hi, new_lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       freq_q <= '0;
    else if (freq_en) freq_q <= freq_d;
  end
endmodule

// File: rtl/cfg_dbuf_port.sv
module cfg_dbuf_port import cfgp_pkg::*; #(
  parameter int NUM_CW      = 32,
  parameter int FREQ_W      = 30,
  parameter int HI_IDX      = 2,
  parameter int LO_IDX      = 3,
  parameter int SYNC_IDX    = 22,
  parameter int SYNC_BIT    = 0,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_cs,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     sync_in,
  output logic [FREQ_W-1:0]        rsmp_freq,
  output logic [NUM_CW*DATA_W-1:0] ctrl_flat,
  output logic                     coef_we,
  output logic [ADDR_W-2:0]        coef_addr,
  output logic [DATA_W-1:0]        coef_data
);
  localparam int HI_W = FREQ_W - DATA_W;

  logic          rst_q;
  logic          wr_fire;
  wr_req_t       req;
  logic          is_coef;
  logic          ctrl_we;
  logic          load_lo;
  logic          sync_take;
  logic [DATA_W-1:0] rd_word;
  logic          coef_we_d;
  logic [ADDR_W-2:0] coef_addr_d;
  logic [DATA_W-1:0] coef_data_d;

  cfgp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  cfgp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst_n(rst_q), .strobe(bus_cs & bus_wr), .fire(wr_fire)
  );

  assign req.addr = bus_addr;
  assign req.data = bus_wdata;
  assign is_coef  = req.addr[ADDR_W-1];
  assign ctrl_we  = wr_fire & ~is_coef;
  assign load_lo  = ctrl_we && (req.addr == ADDR_W'(LO_IDX));
  assign sync_take = sync_in & ctrl_flat[SYNC_IDX*DATA_W + SYNC_BIT];

  cfgp_regfile #(.NUM_CW(NUM_CW)) u_regs (
    .clk(clk), .rst_n(rst_q), .we(ctrl_we),
    .waddr(req.addr[ADDR_W-2:0]), .wdata(req.data),
    .raddr(bus_addr[ADDR_W-2:0]), .rdata(rd_word),
    .words_flat(ctrl_flat)
  );

  cfgp_freq_dbuf #(.FREQ_W(FREQ_W), .LO_W(DATA_W)) u_freq (
    .clk(clk), .rst_n(rst_q),
    .hold_hi(ctrl_flat[HI_IDX*DATA_W +: HI_W]),
    .hold_lo(ctrl_flat[LO_IDX*DATA_W +: DATA_W]),
    .new_lo(req.data), .load_lo(load_lo), .sync_take(sync_take),
    .freq_q(rsmp_freq)
  );

  assign bus_rdata = (bus_cs && bus_rd && !is_coef) ? rd_word : '0;

  always_comb begin
    coef_we_d   = wr_fire & is_coef;
    coef_addr_d = coef_addr;
    coef_data_d = coef_data;
    if (coef_we_d) begin
      coef_addr_d = req.addr[ADDR_W-2:0];
      coef_data_d = req.data;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      coef_we   <= 1'b0;
      coef_addr <= '0;
      coef_data <= '0;
    end else begin
      coef_we <= coef_we_d;
      if (coef_we_d) begin
        coef_addr <= coef_addr_d;
        coef_data <= coef_data_d;
      end
    end
  end
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk import cfgp_pkg::*; #(
  parameter int NUM_CW   = 32,
  parameter int FREQ_W   = 30,
  parameter int LO_IDX   = 3,
  parameter int SYNC_IDX = 22,
  parameter int SYNC_BIT = 0
) (
  input logic                     clk,
  input logic                     rst_q,
  input logic                     bus_cs,
  input logic                     bus_rd,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic                     sync_in,
  input logic [FREQ_W-1:0]        rsmp_freq,
  input logic [NUM_CW*DATA_W-1:0] ctrl_flat,
  input logic                     coef_we,
  input logic                     wr_fire
);
  a_r7_coef_single: assert property (@(posedge clk) disable iff (!rst_q)
    coef_we |=> !coef_we);

  a_r7_coef_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_q)
    coef_we |-> $stable(ctrl_flat));

  a_r4_lo_commit: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_fire && bus_addr == ADDR_W'(LO_IDX)) |=> rsmp_freq[DATA_W-1:0] == $past(bus_wdata));

  a_r6_freq_source: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(rsmp_freq) |->
      ($past(sync_in && ctrl_flat[SYNC_IDX*DATA_W + SYNC_BIT]) ||
       $past(wr_fire && bus_addr == ADDR_W'(LO_IDX))));

  a_r8_read_idle: assert property (@(posedge clk) disable iff (!rst_q)
    !(bus_cs && bus_rd) |-> bus_rdata == '0);

  a_r7_coef_read_zero: assert property (@(posedge clk) disable iff (!rst_q)
    bus_addr[ADDR_W-1] |-> bus_rdata == '0);
endmodule

bind cfg_dbuf_port cfgp_chk #(
  .NUM_CW(NUM_CW), .FREQ_W(FREQ_W), .LO_IDX(LO_IDX),
  .SYNC_IDX(SYNC_IDX), .SYNC_BIT(SYNC_BIT)
) u_chk (
  .clk(clk), .rst_q(rst_q), .bus_cs(bus_cs), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .sync_in(sync_in), .rsmp_freq(rsmp_freq), .ctrl_flat(ctrl_flat),
  .coef_we(coef_we), .wr_fire(wr_fire)
);

// File: tb/cfg_dbuf_port_test.sv
module cfg_dbuf_port_test;
  localparam int NCW = 32;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        sync_in = 1'b0;
  logic [15:0] bus_rdata;
  logic [29:0] rsmp_freq;
  logic [NCW*16-1:0] ctrl_flat;
  logic        coef_we;
  logic [8:0]  coef_addr;
  logic [15:0] coef_data;

  cfg_dbuf_port uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sync_in(sync_in), .rsmp_freq(rsmp_freq), .ctrl_flat(ctrl_flat),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [15:0] m_cw [NCW];
  logic [29:0] m_freq;
  logic        m_cwe;
  logic [8:0]  m_caddr;
  logic [15:0] m_cdata;
  int          pend_due[$];
  int          pend_addr[$];
  logic [15:0] pend_data[$];

  task automatic check(string tag, string what, logic [NCW*16-1:0] act, logic [NCW*16-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model: sync transfer from pre-edge state, then any due write
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < NCW; i++) m_cw[i] = '0;
      m_freq = '0; m_cwe = 1'b0; m_caddr = '0; m_cdata = '0;
    end else begin
      m_cwe = 1'b0;
      if (sync_in && m_cw[22][0]) m_freq = {m_cw[2][13:0], m_cw[3]};
      if (pend_due.size() > 0 && pend_due[0] == cyc) begin
        int a;
        logic [15:0] d;
        a = pend_addr.pop_front();
        d = pend_data.pop_front();
        void'(pend_due.pop_front());
        if (a >= 512) begin
          m_cwe = 1'b1; m_caddr = a[8:0]; m_cdata = d;
        end else if (a < NCW) begin
          m_cw[a] = d;
          if (a == 3) m_freq = {m_cw[2][13:0], d};
        end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (cyc > 0) begin
      logic [NCW*16-1:0] ef;
      for (int i = 0; i < NCW; i++) ef[i*16 +: 16] = m_cw[i];
      check("R4/R6", "rsmp_freq", {482'b0, rsmp_freq}, {482'b0, m_freq});
      check("R3", "ctrl_flat", ctrl_flat, ef);
      check("R7", "coef_we", {511'b0, coef_we}, {511'b0, m_cwe});
      check("R7", "coef_addr", {503'b0, coef_addr}, {503'b0, m_caddr});
      check("R7", "coef_data", {496'b0, coef_data}, {496'b0, m_cdata});
    end
  end

  task automatic do_write(int a, logic [15:0] d, logic cs);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = d; bus_cs = cs; bus_wr = 1'b1;
    if (cs) begin
      pend_due.push_back(cyc + LAT); pend_addr.push_back(a); pend_data.push_back(d);
    end
    repeat (LAT) @(negedge clk);
    bus_wr = 1'b0; bus_cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(string tag, int a, logic cs, logic [15:0] exp);
    @(negedge clk);
    bus_addr = 10'(a); bus_cs = cs; bus_rd = 1'b1;
    #1;
    check(tag, "bus_rdata", {496'b0, bus_rdata}, {496'b0, exp});
    bus_rd = 1'b0; bus_cs = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
    @(negedge clk);
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "freq after reset", {482'b0, rsmp_freq}, '0);
    check("R1", "coef_we after reset", {511'b0, coef_we}, '0);
    check("R1", "rdata idle after reset", {496'b0, bus_rdata}, '0);
    do_read("R1", 0, 1'b1, 16'h0);
    do_read("R1", 22, 1'b1, 16'h0);

    // R5 holding half alone
    do_write(2, 16'h3ABC, 1'b1);
    check("R5", "freq unchanged by word 2", {482'b0, rsmp_freq}, '0);
    do_read("R5", 2, 1'b1, 16'h3ABC);

    // R4 low half commits
    do_write(3, 16'h1234, 1'b1);
    check("R4", "freq after word 3", {482'b0, rsmp_freq}, {482'b0, 14'h3ABC, 16'h1234});
    do_read("R5", 3, 1'b1, 16'h1234);

    // R2 chip enable low
    do_write(5, 16'h5A5A, 1'b0);
    do_read("R2", 5, 1'b1, 16'h0);
    do_write(3, 16'hFFFF, 1'b0);
    check("R2", "freq after gated write", {482'b0, rsmp_freq}, {482'b0, 14'h3ABC, 16'h1234});

    // R3 latency: watch edge by edge
    @(negedge clk);
    bus_addr = 10'd7; bus_wdata = 16'hA5A5; bus_cs = 1'b1; bus_wr = 1'b1;
    pend_due.push_back(cyc + LAT); pend_addr.push_back(7); pend_data.push_back(16'hA5A5);
    @(negedge clk); check("R3", "word 7 one edge in", {496'b0, ctrl_flat[7*16 +: 16]}, '0);
    @(negedge clk); check("R3", "word 7 two edges in", {496'b0, ctrl_flat[7*16 +: 16]}, '0);
    @(negedge clk); check("R3", "word 7 three edges in", {496'b0, ctrl_flat[7*16 +: 16]}, {496'b0, 16'hA5A5});
    repeat (2) @(negedge clk);
    check("R3", "single update per edge", {496'b0, ctrl_flat[7*16 +: 16]}, {496'b0, 16'hA5A5});
    bus_wr = 1'b0; bus_cs = 1'b0;
    repeat (3) @(negedge clk);

    // R9 unmapped gap
    do_write(100, 16'hCAFE, 1'b1);
    do_read("R9", 100, 1'b1, 16'h0);
    do_read("R9", 31, 1'b1, 16'h0);

    // R7 coefficient region
    do_write(10'h2F3, 16'hBEEF, 1'b1);
    check("R7", "coef_addr", {503'b0, coef_addr}, {503'b0, 9'h0F3});
    check("R7", "coef_data", {496'b0, coef_data}, {496'b0, 16'hBEEF});
    do_read("R7", 10'h2F3, 1'b1, 16'h0);

    // R6 sync gated by mode bit
    do_write(2, 16'h0155, 1'b1);
    pulse_sync();
    check("R6", "sync ignored with mode off", {482'b0, rsmp_freq}, {482'b0, 14'h3ABC, 16'h1234});
    do_write(22, 16'h0001, 1'b1);
    pulse_sync();
    check("R6", "sync transfer", {482'b0, rsmp_freq}, {482'b0, 14'h0155, 16'h1234});
    do_write(2, 16'h2222, 1'b1);
    check("R5", "freq holds after word 2", {482'b0, rsmp_freq}, {482'b0, 14'h0155, 16'h1234});
    pulse_sync();
    check("R6", "second sync transfer", {482'b0, rsmp_freq}, {482'b0, 14'h2222, 16'h1234});

    // R8 read needs both strobes
    do_read("R8", 7, 1'b0, 16'h0);
    do_read("R8", 7, 1'b1, 16'hA5A5);
    do_read("R8", 22, 1'b1, 16'h0001);

    repeat (5) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule